// File: doc/BRIEF.md
# Phase-Error Lock Monitor

This block sits beside a three-state phase comparator in a frequency synthesizer loop. It measures how long each up or down correction pulse lasts, using a fast sampling clock. It then decides, one reference period at a time, whether the loop is settled. Lock is declared only after a run of consecutive reference periods in which every pulse stayed within a programmable phase limit. A single pulse that exceeds the limit drops lock at once.

When automatic control is enabled, the lock decision also chooses the charge-pump current. High current is used while acquiring, and also the moment a wide error appears. Low current is used once the loop is locked. When automatic control is off, a manual bit chooses the current. A shared output pin carries either the lock flag or a general-purpose bit. While the synthesizer is in standby, the lock state is held cleared.

Top module: `phase_lock_monitor`

## Requirements
- R1: The pulse width is the number of consecutive sampling cycles in which `up_i` or `dn_i` is high. With the default 2.5 ns sampling period, threshold codes 0, 1, 2 and 3 give limits of 4, 8, 12 and 16 cycles (10/20/30/40 ns). A pulse of at most the limit is good. A pulse one cycle longer is an over-threshold error.
- R2: A reference edge is a rising edge of `ref_i`, and each such edge closes a period. Delay codes 01, 10 and 11 need 4, 6 and 8 consecutive good edges. `in_lock_o` rises in the cycle after the edge that completes the run.
- R3: With delay code 00, `in_lock_o` never rises, however many good periods arrive.
- R4: An over-threshold error clears `in_lock_o` in the next cycle and restarts the count. The edge that closes the period holding that error is not counted as good.
- R5: With `auto_en_i`=1, `hi_cur_o` is 1 in the same cycle as an over-threshold error and whenever `in_lock_o` is 0. It is 0 while the block is locked and no error is present.
- R6: With `auto_en_i`=0, `hi_cur_o` equals `manual_hi_i`, whatever the lock state.
- R7: While `standby_i`=1, `in_lock_o` is 0 from the next cycle on. After release, a full new run of good periods is needed before lock returns.
- R8: `pin_o` equals `in_lock_o` when `pin_sel_i`=1, and equals `gp_bit_i` when `pin_sel_i`=0.
- R9: After reset, `in_lock_o` is 0 and the good-period count is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | Synthesizer standby; holds lock cleared |
| up_i | input | 1 | Phase comparator up pulse |
| dn_i | input | 1 | Phase comparator down pulse |
| ref_i | input | 1 | Reference pulse; each rising edge closes a period |
| thr_code_i | input | 2 | Phase-limit code (10/20/30/40 ns) |
| dly_code_i | input | 2 | Good-period run length code (off/4/6/8) |
| auto_en_i | input | 1 | Automatic current selection enable |
| manual_hi_i | input | 1 | Manual high-current select |
| pin_sel_i | input | 1 | Shared pin source: 1 = lock flag, 0 = GP bit |
| gp_bit_i | input | 1 | General-purpose output bit |
| in_lock_o | output | 1 | Lock flag |
| hi_cur_o | output | 1 | Charge-pump high-current select |
| pin_o | output | 1 | Shared output pin |

## Verification
A wrong pulse-run counter shows up within one pulse. `hi_cur_o` rises one cycle too early or too late, compared with the boundary widths of R1. A wrong good-period count or delay decode shows up on the reference edge where lock should appear: `in_lock_o` rises one period early or one period late. A bad-period flag that is not cleared, or not set, shows up within the next period. Lock then either fails to return after a wide pulse, or returns too soon.

// File: rtl/plm_pkg.sv
package plm_pkg;

    // Picoseconds represented by one step of the threshold code
    localparam int STEP_PS = 10000;

    typedef enum logic [1:0] {
        DLY_OFF = 2'b00,
        DLY_4   = 2'b01,
        DLY_6   = 2'b10,
        DLY_8   = 2'b11
    } dly_code_e;

    // Events passed from the error meter to the lock sequencer
    typedef struct packed {
        logic active;    // an up or down pulse is present
        logic over;      // the current pulse has passed the limit
        logic ref_edge;  // a reference rising edge closes a period
    } err_evt_t;

    // Limit in sampling cycles for a threshold code
    function automatic int thr_cycles(input logic [1:0] code, input int clk_ps);
        int c;
        c = ((int'(code) + 1) * STEP_PS) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    // Good periods needed for a delay code; zero means never lock
    function automatic int dly_periods(input logic [1:0] code);
        if (code == DLY_OFF) return 0;
        return 2 * int'(code) + 2;
    endfunction

endpackage

// File: rtl/plm_err_meter.sv
module plm_err_meter
    import plm_pkg::*;
#(
    parameter int CLK_PS = 2500,
    parameter int RUN_W  = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           up_i,
    input  logic           dn_i,
    input  logic           ref_i,
    input  logic [1:0]     thr_code_i,
    output err_evt_t       evt_o
);

    logic [RUN_W-1:0] lim [4];
    logic [RUN_W-1:0] run_q;
    logic             ref_q;
    logic             active;

    for (genvar g = 0; g < 4; g++) begin : g_lim
        localparam int LIM = thr_cycles(2'(g), CLK_PS);
        assign lim[g] = RUN_W'(LIM);
    end

    assign active = up_i | dn_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            ref_q <= 1'b0;
        end else begin
            ref_q <= ref_i;
            if (!active)
                run_q <= '0;
            else if (run_q != {RUN_W{1'b1}})
                run_q <= run_q + 1'b1;
        end
    end

    always_comb begin
        evt_o          = '0;
        evt_o.active   = active;
        evt_o.over     = active && (run_q >= lim[thr_code_i]);
        evt_o.ref_edge = ref_i & ~ref_q;
    end

endmodule

// File: rtl/plm_lock_seq.sv
module plm_lock_seq
    import plm_pkg::*;
#(
    parameter int GOOD_W = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       standby_i,
    input  err_evt_t   evt_i,
    input  logic [1:0] dly_code_i,
    output logic       lock_o
);

    logic [GOOD_W-1:0] good_q;
    logic [GOOD_W-1:0] good_nx;
    logic [GOOD_W-1:0] need;
    logic              bad_q;
    logic              lock_q;

    assign need    = GOOD_W'(dly_periods(dly_code_i));
    assign good_nx = (good_q == {GOOD_W{1'b1}}) ? good_q : good_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || standby_i) begin
            good_q <= '0;
            bad_q  <= 1'b0;
            lock_q <= 1'b0;
        end else if (evt_i.over) begin
            good_q <= '0;
            bad_q  <= 1'b1;
            lock_q <= 1'b0;
        end else if (evt_i.ref_edge) begin
            bad_q <= 1'b0;
            if (bad_q) begin
                good_q <= '0;
                lock_q <= 1'b0;
            end else begin
                good_q <= good_nx;
                lock_q <= (need != '0) && (good_nx >= need);
            end
        end
    end

    assign lock_o = lock_q;

endmodule

// File: rtl/plm_drive_sel.sv
module plm_drive_sel (
    input  logic auto_en_i,
    input  logic manual_hi_i,
    input  logic over_i,
    input  logic lock_i,
    input  logic pin_sel_i,
    input  logic gp_bit_i,
    output logic hi_cur_o,
    output logic pin_o
);

    always_comb begin
        if (auto_en_i)
            hi_cur_o = over_i | ~lock_i;
        else
            hi_cur_o = manual_hi_i;
        pin_o = pin_sel_i ? lock_i : gp_bit_i;
    end

endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
    import plm_pkg::*;
#(
    parameter int CLK_PS = 2500,
    parameter int GOOD_W = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       standby_i,
    input  logic       up_i,
    input  logic       dn_i,
    input  logic       ref_i,
    input  logic [1:0] thr_code_i,
    input  logic [1:0] dly_code_i,
    input  logic       auto_en_i,
    input  logic       manual_hi_i,
    input  logic       pin_sel_i,
    input  logic       gp_bit_i,
    output logic       in_lock_o,
    output logic       hi_cur_o,
    output logic       pin_o
);

    localparam int MAX_THR = thr_cycles(2'b11, CLK_PS);
    localparam int RUN_W   = $clog2(MAX_THR + 2);

    err_evt_t evt;
    logic     err_over;
    logic     err_edge;
    logic     lock;

    plm_err_meter #(.CLK_PS(CLK_PS), .RUN_W(RUN_W)) u_meter (
        .clk        (clk),
        .rst        (rst),
        .up_i       (up_i),
        .dn_i       (dn_i),
        .ref_i      (ref_i),
        .thr_code_i (thr_code_i),
        .evt_o      (evt)
    );

    plm_lock_seq #(.GOOD_W(GOOD_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .standby_i  (standby_i),
        .evt_i      (evt),
        .dly_code_i (dly_code_i),
        .lock_o     (lock)
    );

    assign err_over = evt.over;
    assign err_edge = evt.ref_edge;

    plm_drive_sel u_drv (
        .auto_en_i   (auto_en_i),
        .manual_hi_i (manual_hi_i),
        .over_i      (err_over),
        .lock_i      (lock),
        .pin_sel_i   (pin_sel_i),
        .gp_bit_i    (gp_bit_i),
        .hi_cur_o    (hi_cur_o),
        .pin_o       (pin_o)
    );

    assign in_lock_o = lock;

endmodule

// File: rtl/plm_checker.sv
module plm_checker (
    input logic       clk,
    input logic       rst,
    input logic       standby_i,
    input logic       auto_en_i,
    input logic [1:0] dly_code_i,
    input logic       in_lock_o,
    input logic       hi_cur_o,
    input logic       err_over,
    input logic       err_edge
);

    // R4
    lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
        err_over |=> !in_lock_o);

    // R7
    standby_clear_chk: assert property (@(posedge clk) disable iff (rst)
        standby_i |=> !in_lock_o);

    // R2
    lock_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_lock_o) |-> $past(err_edge));

    // R3
    no_lock_off_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_lock_o) |-> $past(dly_code_i) != 2'b00);

    // R5
    auto_high_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en_i && err_over) |-> hi_cur_o);

    // R5
    auto_low_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en_i && in_lock_o && !err_over) |-> !hi_cur_o);

endmodule

bind phase_lock_monitor plm_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .standby_i  (standby_i),
    .auto_en_i  (auto_en_i),
    .dly_code_i (dly_code_i),
    .in_lock_o  (in_lock_o),
    .hi_cur_o   (hi_cur_o),
    .err_over   (err_over),
    .err_edge   (err_edge)
);

// File: tb/phase_lock_monitor_tb.sv
module phase_lock_monitor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PERIOD_CYC = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       standby_i = 1'b0;
    logic       up_i = 1'b0;
    logic       dn_i = 1'b0;
    logic       ref_i = 1'b0;
    logic [1:0] thr_code_i = 2'b00;
    logic [1:0] dly_code_i = 2'b01;
    logic       auto_en_i = 1'b1;
    logic       manual_hi_i = 1'b0;
    logic       pin_sel_i = 1'b1;
    logic       gp_bit_i = 1'b0;
    logic       in_lock_o;
    logic       hi_cur_o;
    logic       pin_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_lock_monitor u_dut (
        .clk         (clk),
        .rst         (rst),
        .standby_i   (standby_i),
        .up_i        (up_i),
        .dn_i        (dn_i),
        .ref_i       (ref_i),
        .thr_code_i  (thr_code_i),
        .dly_code_i  (dly_code_i),
        .auto_en_i   (auto_en_i),
        .manual_hi_i (manual_hi_i),
        .pin_sel_i   (pin_sel_i),
        .gp_bit_i    (gp_bit_i),
        .in_lock_o   (in_lock_o),
        .hi_cur_o    (hi_cur_o),
        .pin_o       (pin_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive inputs after a falling edge and let combinational paths settle
    task automatic drive(input logic u, input logic d, input logic r);
        @(negedge clk);
        up_i  = u;
        dn_i  = d;
        ref_i = r;
        #1;
    endtask

    // One reference period: ref pulse, then a pulse of w cycles
    task automatic run_period(input int w, input bit use_dn);
        drive(1'b0, 1'b0, 1'b1);
        for (int i = 1; i < PERIOD_CYC; i++)
            drive(!use_dn && (i <= w), use_dn && (i <= w), 1'b0);
    endtask

    task automatic apply_reset();
        rst = 1'b1;
        standby_i = 1'b0;
        auto_en_i = 1'b1;
        pin_sel_i = 1'b1;
        repeat (3) drive(1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        drive(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        thr_code_i = 2'b00; dly_code_i = 2'b01;
        apply_reset();
        chk("R9 lock after reset", in_lock_o, 1'b0);
        chk("R5 high current while unlocked", hi_cur_o, 1'b1);
    endtask

    task automatic t_delay4();
        thr_code_i = 2'b00; dly_code_i = 2'b01;
        apply_reset();
        repeat (3) run_period(4, 1'b0);
        chk("R2 not locked after 3 edges", in_lock_o, 1'b0);
        run_period(4, 1'b0);
        chk("R1 width at limit is good / R2 lock after 4 edges", in_lock_o, 1'b1);
        chk("R5 low current while locked", hi_cur_o, 1'b0);
    endtask

    task automatic t_loss();
        thr_code_i = 2'b00; dly_code_i = 2'b01;
        apply_reset();
        repeat (4) run_period(4, 1'b0);
        drive(1'b0, 1'b0, 1'b1);
        repeat (4) drive(1'b1, 1'b0, 1'b0);
        chk("R1 four cycles still good", hi_cur_o, 1'b0);
        drive(1'b1, 1'b0, 1'b0);
        chk("R5 high current same cycle as error", hi_cur_o, 1'b1);
        chk("R4 lock held until edge", in_lock_o, 1'b1);
        drive(1'b0, 1'b0, 1'b0);
        chk("R4 lock dropped next cycle", in_lock_o, 1'b0);
        chk("R5 high current after loss", hi_cur_o, 1'b1);
    endtask

    task automatic t_bad_period();
        thr_code_i = 2'b00; dly_code_i = 2'b01;
        apply_reset();
        repeat (2) run_period(4, 1'b0);
        run_period(5, 1'b0);
        repeat (4) run_period(4, 1'b0);
        chk("R4 bad period not counted", in_lock_o, 1'b0);
        run_period(4, 1'b0);
        chk("R4 lock after fresh run", in_lock_o, 1'b1);
    endtask

    task automatic t_thresholds();
        thr_code_i = 2'b11; dly_code_i = 2'b01;
        apply_reset();
        repeat (4) run_period(16, 1'b1);
        chk("R1 code 3 width 16 good", in_lock_o, 1'b1);
        run_period(17, 1'b1);
        chk("R1 code 3 width 17 bad", in_lock_o, 1'b0);
        thr_code_i = 2'b01;
        apply_reset();
        repeat (4) run_period(9, 1'b0);
        chk("R1 code 1 width 9 bad", in_lock_o, 1'b0);
        thr_code_i = 2'b10;
        apply_reset();
        repeat (4) run_period(12, 1'b1);
        chk("R1 code 2 width 12 good", in_lock_o, 1'b1);
    endtask

    task automatic t_delay8();
        thr_code_i = 2'b00; dly_code_i = 2'b11;
        apply_reset();
        repeat (7) run_period(2, 1'b0);
        chk("R2 code 11 not locked after 7", in_lock_o, 1'b0);
        run_period(2, 1'b0);
        chk("R2 code 11 locked after 8", in_lock_o, 1'b1);
        dly_code_i = 2'b10;
        apply_reset();
        repeat (5) run_period(2, 1'b0);
        chk("R2 code 10 not locked after 5", in_lock_o, 1'b0);
        run_period(2, 1'b0);
        chk("R2 code 10 locked after 6", in_lock_o, 1'b1);
    endtask

    task automatic t_delay_off();
        thr_code_i = 2'b00; dly_code_i = 2'b00;
        apply_reset();
        repeat (12) run_period(1, 1'b0);
        chk("R3 code 00 never locks", in_lock_o, 1'b0);
    endtask

    task automatic t_standby();
        thr_code_i = 2'b00; dly_code_i = 2'b01;
        apply_reset();
        repeat (4) run_period(3, 1'b0);
        chk("R7 locked before standby", in_lock_o, 1'b1);
        standby_i = 1'b1;
        drive(1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0);
        chk("R7 standby clears lock", in_lock_o, 1'b0);
        standby_i = 1'b0;
        repeat (3) run_period(3, 1'b0);
        chk("R7 count restarted", in_lock_o, 1'b0);
        run_period(3, 1'b0);
        chk("R7 relock after full run", in_lock_o, 1'b1);
    endtask

    task automatic t_manual_and_pin();
        thr_code_i = 2'b00; dly_code_i = 2'b01;
        apply_reset();
        auto_en_i = 1'b0;
        manual_hi_i = 1'b1;
        drive(1'b0, 1'b0, 1'b0);
        chk("R6 manual high while unlocked", hi_cur_o, 1'b1);
        manual_hi_i = 1'b0;
        drive(1'b0, 1'b0, 1'b0);
        chk("R6 manual low while unlocked", hi_cur_o, 1'b0);
        repeat (4) run_period(4, 1'b0);
        manual_hi_i = 1'b1;
        drive(1'b0, 1'b0, 1'b0);
        chk("R6 manual high while locked", hi_cur_o, 1'b1);
        pin_sel_i = 1'b1;
        drive(1'b0, 1'b0, 1'b0);
        chk("R8 pin shows lock", pin_o, 1'b1);
        pin_sel_i = 1'b0; gp_bit_i = 1'b0;
        drive(1'b0, 1'b0, 1'b0);
        chk("R8 pin shows gp bit low", pin_o, 1'b0);
        gp_bit_i = 1'b1;
        apply_reset();
        pin_sel_i = 1'b0;
        drive(1'b0, 1'b0, 1'b0);
        chk("R8 pin shows gp bit high while unlocked", pin_o, 1'b1);
    endtask

    initial begin
        t_reset();
        t_delay4();
        t_loss();
        t_bad_period();
        t_thresholds();
        t_delay8();
        t_delay_off();
        t_standby();
        t_manual_and_pin();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule